// File: doc/BRIEF.md
# Indexed Serial Register Read Controller

This block lets software fetch register contents from one of several remote error-monitor instances over a narrow two-wire side link. Software writes a control word that names an instance and an 8-bit remote register address and sets a start bit. The block sends the instance number and the address to the remote side as one serial request. It then collects eight 32-bit response words, one bit per valid cycle, and stores them in a readback window that software can read through a simple 32-bit register bus.

When the eighth word has been stored, a completion flag is raised. Software clears the flag with any write to the control word. If the remote side stops answering for too long, the fetch is abandoned. The completion flag is raised anyway, and a single-cycle timeout event is sent to a downstream error counter. Instance 0 is the system-level monitor and instances 1 to 3 are the per-CPU monitors. A read-only status word reports how many instances are serviced.

Top module: `sidebus_reader`

## Requirements
- R1: After reset the control word, every window word, `sb_req`, `sb_tx` and `tmo_evt` are all zero.
- R2: Offset 0x00 reads the constant 0x46A00201: scheme 1 in bits 31:30, module id 0x6A0 in bits 27:16, major 2 in bits 10:8 and minor 1 in bits 5:0. Offset 0x0C reads the serviced-instance count, 4, in bits 10:0 and zero in every other bit.
- R3: In the control word at offset 0x08, the instance selector in bits 10:0 and the remote address in bits 23:16 read back the last value written to them.
- R4: A control write with bit 15 = 1 while the block is idle makes bit 15 read 1 for exactly one cycle, and `sb_req` rises in the following cycle. A control write with bit 15 = 0 starts nothing.
- R5: A request keeps `sb_req` high for 19 consecutive cycles. Over those cycles `sb_tx` carries the 11-bit selector and then the 8-bit address, each most significant bit first.
- R6: After the request, each cycle with `sb_rsp_valid` high shifts in one bit of `sb_rsp_bit`, most significant bit first. Each group of 32 bits becomes window word y (y = 0..7, in order), which reads at offset 0x10 + 4*y.
- R7: The cycle after the eighth word is stored, bit 24 of the control word reads 1. Any later control write clears it by the next cycle.
- R8: A control write with bit 15 = 1 while a fetch is in progress starts no new request and leaves bit 15 reading 0.
- R9: If `sb_rsp_valid` stays low for TMO_CYCLES consecutive cycles while responses are expected, the fetch aborts. In that case bit 24 is set, `tmo_evt` is high for exactly one cycle, and words already completed stay in the window while the remaining words keep their earlier values.
- R10: Offsets other than 0x00, 0x08, 0x0C and 0x10..0x2C, as well as unaligned offsets, read as zero. Writes to them, and writes to the window, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr`, combinational |
| sb_req | output | 1 | High while a request frame is being sent |
| sb_tx | output | 1 | Serial request bit |
| sb_rsp_valid | input | 1 | Response bit strobe |
| sb_rsp_bit | input | 1 | Serial response bit |
| tmo_evt | output | 1 | One-cycle pulse when a fetch times out |

## Verification
A start write is taken at edge E0, and bit 15 reads 1 only in the cycle after E0. The request occupies the cycles after E1 through E19, so the bench samples `sb_tx` at the falling edge after each of those rising edges. The response phase begins at E20, and the bench drives response bits on falling edges. The done flag and the final window word are due in the cycle after the edge that samples the last bit. After the last valid bit the bench counts falling edges and requires `tmo_evt` to be high at exactly the TMO_CYCLES-th one and at no other. Every register read happens at a falling edge, so each result is compared one full register stage after the edge that produces it.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam logic [31:0] ID_WORD  = 32'h46A0_0201;
  localparam logic [7:0]  OFS_ID   = 8'h00;
  localparam logic [7:0]  OFS_CTRL = 8'h08;
  localparam logic [7:0]  OFS_STAT = 8'h0C;
  localparam logic [7:0]  OFS_WIN  = 8'h10;
  localparam int CTRL_TRIG_BIT  = 15;
  localparam int CTRL_ADDR_LSB  = 16;
  localparam int CTRL_DONE_BIT  = 24;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_RECV = 2'd2
  } sbr_state_e;
endpackage

// File: rtl/sbr_tx_shift.sv
module sbr_tx_shift #(
  parameter int FRAME_W = 19
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_val,
  input  logic               shift_en,
  output logic               bit_out
);
  logic [FRAME_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load)          sh_d = load_val;
    else if (shift_en) sh_d = {sh_q[FRAME_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign bit_out = sh_q[FRAME_W-1];
endmodule

// File: rtl/sbr_rx_assemble.sv
module sbr_rx_assemble #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 8,
  localparam int BIT_W    = $clog2(WORD_W),
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              bit_valid,
  input  logic              bit_in,
  output logic              word_valid,
  output logic [IDX_W-1:0]  word_idx,
  output logic [WORD_W-1:0] word_data,
  output logic              last_word
);
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [BIT_W-1:0]  bcnt_q, bcnt_d;
  logic [IDX_W-1:0]  widx_q, widx_d;
  logic              word_done;

  assign word_done  = bit_valid && (bcnt_q == BIT_W'(WORD_W - 1));
  assign word_valid = word_done;
  assign word_idx   = widx_q;
  assign word_data  = {sh_q[WORD_W-2:0], bit_in};
  assign last_word  = word_done && (widx_q == IDX_W'(NUM_WORDS - 1));

  always_comb begin
    sh_d   = sh_q;
    bcnt_d = bcnt_q;
    widx_d = widx_q;
    if (clear) begin
      sh_d   = '0;
      bcnt_d = '0;
      widx_d = '0;
    end else if (bit_valid) begin
      sh_d   = word_data;
      bcnt_d = word_done ? '0 : bcnt_q + 1'b1;
      if (word_done) widx_d = widx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bcnt_q <= '0;
      widx_q <= '0;
    end else begin
      sh_q   <= sh_d;
      bcnt_q <= bcnt_d;
      widx_q <= widx_d;
    end
  end
endmodule

// File: rtl/sbr_window.sv
module sbr_window #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 8,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] words [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] q;
    logic              en;
    assign en = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wr_data;
    end
    assign words[g] = q;
  end

  assign rd_data = words[rd_idx];
endmodule

// File: rtl/sidebus_reader.sv
module sidebus_reader
  import sbr_pkg::*;
#(
  parameter int SEL_W      = 11,
  parameter int RADDR_W    = 8,
  parameter int WORD_W     = 32,
  parameter int NUM_WORDS  = 8,
  parameter int NUM_INST   = 4,
  parameter int TMO_CYCLES = 64,
  parameter int BUS_AW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sb_req,
  output logic              sb_tx,
  input  logic              sb_rsp_valid,
  input  logic              sb_rsp_bit,
  output logic              tmo_evt
);
  localparam int FRAME_W = SEL_W + RADDR_W;
  localparam int FCNT_W  = $clog2(FRAME_W);
  localparam int TCNT_W  = $clog2(TMO_CYCLES + 1);
  localparam int IDX_W   = $clog2(NUM_WORDS);
  localparam logic [BUS_AW-1:0] WIN_LO = BUS_AW'(OFS_WIN);
  localparam logic [BUS_AW-1:0] WIN_HI = BUS_AW'(OFS_WIN + 4 * NUM_WORDS);

  sbr_state_e           st_q, st_d;
  logic [SEL_W-1:0]     sel_q, sel_d;
  logic [RADDR_W-1:0]   raddr_q, raddr_d;
  logic                 trig_q, trig_d;
  logic                 done_q, done_d;
  logic                 evt_q, evt_d;
  logic [FCNT_W-1:0]    fcnt_q, fcnt_d;
  logic [TCNT_W-1:0]    tcnt_q, tcnt_d;

  logic                 ctrl_wr, tx_load, tx_shift, tx_bit, rx_clear, rx_valid;
  logic                 word_valid, last_word;
  logic [IDX_W-1:0]     word_idx, rd_idx;
  logic [WORD_W-1:0]    word_data, win_rdata;
  logic [BUS_AW-1:0]    win_off;

  assign ctrl_wr  = bus_we && (bus_addr == BUS_AW'(OFS_CTRL));
  assign rx_valid = (st_q == ST_RECV) && sb_rsp_valid;

  // next-state: register writes first, sequencer afterwards so its set wins
  always_comb begin
    st_d     = st_q;
    sel_d    = sel_q;
    raddr_d  = raddr_q;
    trig_d   = trig_q;
    done_d   = done_q;
    evt_d    = 1'b0;
    fcnt_d   = fcnt_q;
    tcnt_d   = tcnt_q;
    tx_load  = 1'b0;
    tx_shift = 1'b0;
    rx_clear = 1'b0;

    if (ctrl_wr) begin
      sel_d   = bus_wdata[SEL_W-1:0];
      raddr_d = bus_wdata[CTRL_ADDR_LSB +: RADDR_W];
      done_d  = 1'b0;
      if (bus_wdata[CTRL_TRIG_BIT] && st_q == ST_IDLE && !trig_q) trig_d = 1'b1;
    end

    unique case (st_q)
      ST_IDLE: begin
        if (trig_q) begin
          trig_d  = 1'b0;
          tx_load = 1'b1;
          fcnt_d  = '0;
          st_d    = ST_SEND;
        end
      end
      ST_SEND: begin
        tx_shift = 1'b1;
        if (fcnt_q == FCNT_W'(FRAME_W - 1)) begin
          st_d     = ST_RECV;
          tcnt_d   = '0;
          rx_clear = 1'b1;
        end else begin
          fcnt_d = fcnt_q + 1'b1;
        end
      end
      ST_RECV: begin
        if (sb_rsp_valid) begin
          tcnt_d = '0;
          if (last_word) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end
        end else if (tcnt_q == TCNT_W'(TMO_CYCLES - 1)) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          evt_d  = 1'b1;
        end else begin
          tcnt_d = tcnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sel_q   <= '0;
      raddr_q <= '0;
      trig_q  <= 1'b0;
      done_q  <= 1'b0;
      evt_q   <= 1'b0;
      fcnt_q  <= '0;
      tcnt_q  <= '0;
    end else begin
      st_q    <= st_d;
      sel_q   <= sel_d;
      raddr_q <= raddr_d;
      trig_q  <= trig_d;
      done_q  <= done_d;
      evt_q   <= evt_d;
      fcnt_q  <= fcnt_d;
      tcnt_q  <= tcnt_d;
    end
  end

  sbr_tx_shift #(.FRAME_W(FRAME_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tx_load),
    .load_val ({sel_q, raddr_q}),
    .shift_en (tx_shift),
    .bit_out  (tx_bit)
  );

  sbr_rx_assemble #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (rx_clear),
    .bit_valid  (rx_valid),
    .bit_in     (sb_rsp_bit),
    .word_valid (word_valid),
    .word_idx   (word_idx),
    .word_data  (word_data),
    .last_word  (last_word)
  );

  assign win_off = bus_addr - WIN_LO;
  assign rd_idx  = win_off[2 +: IDX_W];

  sbr_window #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (word_valid),
    .wr_idx  (word_idx),
    .wr_data (word_data),
    .rd_idx  (rd_idx),
    .rd_data (win_rdata)
  );

  assign sb_req  = (st_q == ST_SEND);
  assign sb_tx   = sb_req && tx_bit;
  assign tmo_evt = evt_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[1:0] == 2'b00) begin
      if (bus_addr == BUS_AW'(OFS_ID)) begin
        bus_rdata = ID_WORD;
      end else if (bus_addr == BUS_AW'(OFS_CTRL)) begin
        bus_rdata[SEL_W-1:0]                  = sel_q;
        bus_rdata[CTRL_TRIG_BIT]              = trig_q;
        bus_rdata[CTRL_ADDR_LSB +: RADDR_W]   = raddr_q;
        bus_rdata[CTRL_DONE_BIT]              = done_q;
      end else if (bus_addr == BUS_AW'(OFS_STAT)) begin
        bus_rdata = 32'(NUM_INST);
      end else if (bus_addr >= WIN_LO && bus_addr < WIN_HI) begin
        bus_rdata = 32'(win_rdata);
      end
    end
  end
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker
  import sbr_pkg::*;
#(
  parameter int BUS_AW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              sb_req,
  input logic              tmo_evt,
  input logic [1:0]        st,
  input logic              trig,
  input logic              done
);
  logic ctrl_wr;
  assign ctrl_wr = bus_we && (bus_addr == BUS_AW'(OFS_CTRL));

  // R4: a pending start launches the request frame on the next cycle
  p_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'(ST_IDLE) && trig) |=> (sb_req && !trig));

  // R8: a start write during a fetch leaves nothing pending
  p_busy_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'(ST_IDLE) && ctrl_wr && bus_wdata[CTRL_TRIG_BIT]) |=> !trig);

  // R7: a control write while idle clears the completion flag
  p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'(ST_IDLE) && ctrl_wr) |=> !done);

  // R9: the timeout event lasts a single cycle
  p_evt_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> !tmo_evt);

  // R9: the abort leaves the block idle with the completion flag set
  p_evt_aborts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |-> (st == 2'(ST_IDLE) && done && !sb_req));
endmodule

bind sidebus_reader sbr_checker #(.BUS_AW(BUS_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .sb_req    (sb_req),
  .tmo_evt   (tmo_evt),
  .st        (st_q),
  .trig      (trig_q),
  .done      (done_q)
);

// File: tb/sidebus_reader_bench.sv
module sidebus_reader_bench;
  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        sb_req, sb_tx, sb_rsp_valid, sb_rsp_bit, tmo_evt;

  int errs = 0;
  int checks = 0;
  logic [31:0] exp_win [8];

  always #5 clk = ~clk;

  sidebus_reader #(.TMO_CYCLES(TMO)) u_sidebus_reader (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sb_req(sb_req),
    .sb_tx(sb_tx), .sb_rsp_valid(sb_rsp_valid), .sb_rsp_bit(sb_rsp_bit),
    .tmo_evt(tmo_evt)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  function automatic logic [31:0] ctl(int s, int ra, bit t);
    return (32'(ra & 8'hFF) << 16) | (32'(t) << 15) | 32'(s & 11'h7FF);
  endfunction

  function automatic logic [31:0] mkw(int s, int ra, int w);
    return 32'(s * 1000 + ra * 8 + w + 1) * 32'h9E37_79B1;
  endfunction

  task automatic check_window(string req);
    logic [31:0] d;
    for (int y = 0; y < 8; y++) begin
      rd(8'(8'h10 + 4 * y), d);
      check(req, d, exp_win[y]);
    end
  endtask

  // one fetch: start, capture request, answer nbits response bits
  task automatic fetch(int s, int ra, int gap, bit poke, int nbits);
    logic [31:0] d;
    logic [18:0] frame;
    logic [31:0] word;
    wr(8'h08, ctl(s, ra, 1'b1));
    rd(8'h08, d);
    check("R4 trigger bit visible one cycle", 32'(d[15]), 32'd1);
    check("R3 selector/address readback", d & 32'h00FF_07FF, ctl(s, ra, 1'b0));
    check("R4 no request yet", 32'(sb_req), 32'd0);
    @(negedge clk);
    rd(8'h08, d);
    check("R4 trigger bit self-clears", 32'(d[15]), 32'd0);
    for (int i = 0; i < 19; i++) begin
      if (sb_req !== 1'b1) begin
        check("R5 request length", 32'(i), 32'd19);
        break;
      end
      frame = {frame[17:0], sb_tx};
      @(negedge clk);
    end
    check("R5 request ends after 19 bits", 32'(sb_req), 32'd0);
    check("R5 request frame content", 32'(frame), 32'({11'(s), 8'(ra)}));
    for (int n = 0; n < nbits; n++) begin
      int w = n / 32;
      int b = 31 - (n % 32);
      word = mkw(s, ra, w);
      if (gap > 0 && b == 16) begin
        sb_rsp_valid = 1'b0;
        repeat (gap) @(negedge clk);
      end
      if (poke && w == 5 && b == 0) begin
        sb_rsp_valid = 1'b0;
        wr(8'h08, ctl(s + 1, ra, 1'b1));
        rd(8'h08, d);
        check("R8 start ignored while busy", 32'(d[15]), 32'd0);
      end
      sb_rsp_valid = 1'b1;
      sb_rsp_bit   = word[b];
      @(negedge clk);
      if (b == 0) exp_win[w] = word;
    end
    sb_rsp_valid = 1'b0;
    sb_rsp_bit   = 1'b0;
    if (nbits < 256) begin
      for (int k = 1; k <= TMO + 1; k++) begin
        @(negedge clk);
        if (k == TMO || tmo_evt !== 1'b0)
          check("R9 timeout pulse timing", 32'(tmo_evt), 32'(k == TMO));
      end
    end else begin
      check("R9 no timeout on complete fetch", 32'(tmo_evt), 32'd0);
    end
    rd(8'h08, d);
    check("R7 done set", 32'(d[24]), 32'd1);
    check_window(nbits < 256 ? "R9 window after abort" : "R6 window contents");
    if (poke) begin
      repeat (30) begin
        @(negedge clk);
        if (sb_req !== 1'b0) check("R8 no second request", 32'(sb_req), 32'd0);
      end
      check("R8 stayed idle", 32'(sb_req), 32'd0);
    end
    wr(8'h08, ctl(s, ra, 1'b0));
    rd(8'h08, d);
    check("R7 done cleared by write", 32'(d[24]), 32'd0);
    repeat (25) begin
      @(negedge clk);
      if (sb_req !== 1'b0) check("R4 write of 0 starts nothing", 32'(sb_req), 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired act=%0d exp=0", 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    sb_rsp_valid = 1'b0; sb_rsp_bit = 1'b0;
    for (int y = 0; y < 8; y++) exp_win[y] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(8'h08, d); check("R1 control reset", d, 32'h0);
    check("R1 outputs reset", {29'h0, sb_req, sb_tx, tmo_evt}, 32'h0);
    check_window("R1 window reset");
    rd(8'h00, d); check("R2 identification", d, 32'h46A0_0201);
    rd(8'h0C, d); check("R2 instance count", d, 32'd4);

    foreach (exp_win[y]) begin end
    rd(8'h04, d); check("R10 hole reads zero", d, 0);
    rd(8'h30, d); check("R10 past window reads zero", d, 0);
    rd(8'h0A, d); check("R10 unaligned reads zero", d, 0);
    rd(8'hFC, d); check("R10 top offset reads zero", d, 0);

    // sweep over all instances and several addresses
    for (int s = 0; s < 4; s++) begin
      for (int j = 0; j < 3; j++) begin
        int ra = (j == 0) ? 8'h00 : (j == 1) ? 8'h5A : 8'hFF;
        fetch(s, ra, (j == 1) ? TMO - 1 : 0, 1'b0, 256);
      end
    end
    fetch(11'h7FF, 8'hA5, 0, 1'b0, 256);

    // R10: writes to undefined offsets and the window change nothing
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h00, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h04, d); check("R10 hole ignores write", d, 0);
    rd(8'h00, d); check("R10 id ignores write", d, 32'h46A0_0201);
    rd(8'h0C, d); check("R10 status ignores write", d, 32'd4);
    check_window("R10 window ignores write");

    // R8: start during fetch
    fetch(2, 8'h33, 0, 1'b1, 256);

    // R9: abort mid-word, abort with no response at all
    fetch(1, 8'h77, 0, 1'b0, 40);
    fetch(3, 8'h12, 0, 1'b0, 0);
    fetch(0, 8'h44, 0, 1'b0, 96);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule